// File: doc/BRIEF.md
# SD Card Data Receive Controller

This block is the receive side of the data path in an SD/MMC host. It follows the command path. When a read command that expects data is loaded, it waits for that command's end bit. It then samples the single card data line, packs the bits into bytes with the most significant bit first, and writes each byte to a FIFO.

Two framing modes are supported. In block mode the card sends start-bit-framed blocks. In stream mode the card sends an unframed bit stream. Either mode can run for a fixed number of bytes or stay open until a STOP command completes. The controller also does three supporting jobs:
- It can request an automatically generated STOP command, timed so that the command ends just after the last data bit.
- It reports a data timeout when a block never starts.
- It holds the card clock while the FIFO is full during a stream.

The card clock is modelled as the block's own clock. No bit is sampled in a cycle in which `card_clk_hold` is high.

Top module: `sd_rx_engine`

## Requirements
- R1: Reception is armed only by `cmd_load` with `cmd_data_exp`=1 and `cmd_is_read`=1. The first card bit is sampled at the second rising edge after the edge that sees `cmd_end`=1. A load with `cmd_is_read`=0 is ignored: no FIFO write, no done and no timeout follow it.
- R2: Bits are packed most significant bit first. `fifo_wr` is high for exactly one cycle, in the cycle after the eighth bit of a byte is sampled, and `fifo_wdata` holds the byte in that cycle.
- R3: With `cfg_stream`=0, a block begins when a 0 is sampled while waiting. It carries `cfg_blk_size` data bytes followed by one end bit. A fixed transfer (`cfg_byte_cnt`≠0) raises `xfer_done` for one cycle once all `cfg_byte_cnt` bytes have arrived.
- R4: After each block the controller waits again. Samples of 1 before a start bit are not stored.
- R5: With `cfg_stream`=0 and `cfg_byte_cnt`=0, blocks continue until `stop_end` is seen. A stop during a block ends the transfer once that block completes. A stop while waiting ends it at once.
- R6: With `cfg_stream`=1, data bits are taken from the first sampled bit, with no start bit. A fixed stream raises `xfer_done` in the cycle after its last bit is sampled.
- R7: An open stream (`cfg_byte_cnt`=0) raises `xfer_done` at the second rising edge after the edge that sees `stop_end`=1.
- R8: During a stream, `card_clk_hold` follows `fifo_full`. No bit is consumed while it is high, and reception resumes without loss once `fifo_full` drops.
- R9: While waiting for a start bit, `cfg_timeout` consecutive samples of 1 raise `data_timeout` and `xfer_done` together for one cycle, and the controller returns to idle.
- R10: With `cfg_auto_stop`=1 and `cfg_byte_cnt`≠0, `auto_stop_req` pulses once, in the cycle after the sample that leaves exactly `AUTO_LEAD` data bits still to come. If the transfer holds `AUTO_LEAD` or fewer bits, the pulse comes in the cycle before the first sample.
- R11: After reset, every output is 0.
- R12: `auto_stop_req` never pulses when `cfg_auto_stop`=0 or `cfg_byte_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | New command loaded into the command path |
| cmd_data_exp | input | 1 | Loaded command carries data |
| cmd_is_read | input | 1 | Loaded command reads from the card |
| cmd_end | input | 1 | End bit of the loaded command |
| stop_end | input | 1 | End bit of a STOP command |
| cfg_stream | input | 1 | 1: stream, 0: blocks |
| cfg_byte_cnt | input | BCW | Transfer length in bytes, 0 = open-ended |
| cfg_blk_size | input | BSW | Bytes per block, nonzero |
| cfg_auto_stop | input | 1 | Enable the automatic STOP request |
| cfg_timeout | input | TW | Start-bit wait limit in samples |
| card_dat | input | 1 | Card data line |
| fifo_full | input | 1 | Receive FIFO cannot accept data |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | Byte written |
| card_clk_hold | output | 1 | Stop the card clock |
| auto_stop_req | output | 1 | Issue the STOP command now |
| xfer_done | output | 1 | Transfer finished (pulse) |
| data_timeout | output | 1 | No start bit in time (pulse) |

## Verification
The FIFO byte stream is checked under several patterns:
- Framed blocks preceded by idle ones, which shows whether idle bits leak into the data.
- A plain stream with a known first-bit edge, which pins the two-cycle start gap and the exact done cycle.
- A stream interrupted by a full FIFO, which separates a true clock hold from dropped or duplicated bits.

Open-ended transfers are ended by a STOP pulse placed either in mid-block or in mid-stream, which tells apart the block-completion rule from the fixed two-cycle drain. Long and short fixed streams with auto-stop enabled place the request pulse on its exact cycle. An endless idle line and a write-direction load show that only the right conditions leave idle.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMDW,
    ST_GAP,
    ST_RDWAIT,
    ST_RXBLK,
    ST_ENDBIT,
    ST_BLKDONE,
    ST_RXSTRM
  } rx_state_e;
endpackage

// File: rtl/sdrx_deser.sv
module sdrx_deser #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp_en,
  input  logic          din,
  output logic          byte_wr,
  output logic [DW-1:0] byte_data
);
  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] LAST = IW'(DW - 1);

  logic [DW-1:0] shift_q, shift_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          wr_q, wr_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    shift_d = shift_q;
    idx_d   = idx_q;
    data_d  = data_q;
    wr_d    = 1'b0;
    if (clr) begin
      idx_d = '0;
    end else if (smp_en) begin
      shift_d = {shift_q[DW-2:0], din};
      idx_d   = idx_q + 1'b1;
      if (idx_q == LAST) begin
        wr_d   = 1'b1;
        data_d = {shift_q[DW-2:0], din};
        idx_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      shift_q <= shift_d;
      idx_q   <= idx_d;
      wr_q    <= wr_d;
      data_q  <= data_d;
    end
  end

  assign byte_wr   = wr_q;
  assign byte_data = data_q;

  // R2
  wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  // R2
  wr_follows_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_q) |-> $past(smp_en));
endmodule

// File: rtl/sdrx_wdog.sv
module sdrx_wdog #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (run) begin
      cnt_d = tick ? cnt_q + 1'b1 : cnt_q;
    end
  end

  assign expire = run && tick && (cnt_q == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/sdrx_ctrl.sv
module sdrx_ctrl
  import sdrx_pkg::*;
#(
  parameter int BCW       = 16,
  parameter int BSW       = 12,
  parameter int AUTO_LEAD = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_load,
  input  logic           cmd_data_exp,
  input  logic           cmd_is_read,
  input  logic           cmd_end,
  input  logic           stop_end,
  input  logic           cfg_stream,
  input  logic [BCW-1:0] cfg_byte_cnt,
  input  logic [BSW-1:0] cfg_blk_size,
  input  logic           cfg_auto_stop,
  input  logic           din,
  input  logic           fifo_full,
  input  logic           expire,
  output logic           wd_run,
  output logic           smp_en,
  output logic           des_clr,
  output logic           rx_hold,
  output logic           xfer_done,
  output logic           data_timeout,
  output logic           auto_stop_req
);
  localparam int BLW = BCW + 3;
  localparam int BKW = BSW + 3;
  localparam logic [BLW-1:0] LEAD  = BLW'(AUTO_LEAD);
  localparam logic [BLW-1:0] LEAD1 = BLW'(AUTO_LEAD + 1);

  rx_state_e      state_q, state_d;
  logic [BLW-1:0] bits_left_q, bits_left_d;
  logic [BKW-1:0] blk_left_q, blk_left_d;
  logic [1:0]     drain_q, drain_d;
  logic           stream_q, stream_d;
  logic           open_q, open_d;
  logic           auto_q, auto_d;
  logic           stop_seen_q, stop_seen_d;
  logic           done_q, done_d;
  logic           tmo_q, tmo_d;
  logic           req_q, req_d;

  assign wd_run  = (state_q == ST_RDWAIT);
  assign rx_hold = (state_q == ST_RXSTRM) && fifo_full;
  assign smp_en  = (state_q == ST_RXBLK) || ((state_q == ST_RXSTRM) && !fifo_full);
  assign des_clr = (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    bits_left_d = bits_left_q;
    blk_left_d  = blk_left_q;
    drain_d     = drain_q;
    stream_d    = stream_q;
    open_d      = open_q;
    auto_d      = auto_q;
    stop_seen_d = stop_seen_q;
    done_d      = 1'b0;
    tmo_d       = 1'b0;
    req_d       = 1'b0;

    if (stop_end && state_q != ST_IDLE && state_q != ST_CMDW) begin
      stop_seen_d = 1'b1;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_load && cmd_data_exp && cmd_is_read) begin
          state_d     = ST_CMDW;
          bits_left_d = {cfg_byte_cnt, 3'b000};
          open_d      = (cfg_byte_cnt == '0);
          stream_d    = cfg_stream;
          auto_d      = cfg_auto_stop;
          stop_seen_d = 1'b0;
          drain_d     = 2'd0;
        end
      end
      ST_CMDW: begin
        if (cmd_end) state_d = ST_GAP;
      end
      ST_GAP: begin
        if (auto_q && !open_q && bits_left_q <= LEAD) req_d = 1'b1;
        state_d = stream_q ? ST_RXSTRM : ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (stop_seen_q || stop_end) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (expire) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          tmo_d   = 1'b1;
        end else if (!din) begin
          state_d    = ST_RXBLK;
          blk_left_d = {cfg_blk_size, 3'b000};
        end
      end
      ST_RXBLK: begin
        if (!open_q && bits_left_q != '0) bits_left_d = bits_left_q - 1'b1;
        blk_left_d = blk_left_q - 1'b1;
        if (blk_left_q == BKW'(1)) state_d = ST_ENDBIT;
      end
      ST_ENDBIT: begin
        state_d = ST_BLKDONE;
      end
      ST_BLKDONE: begin
        if ((!open_q && bits_left_q == '0) || stop_seen_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_RDWAIT;
        end
      end
      ST_RXSTRM: begin
        if (drain_q == 2'd2) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          if (drain_q == 2'd1)  drain_d = 2'd2;
          else if (stop_end)    drain_d = 2'd1;
          if (!fifo_full && !open_q) begin
            if (bits_left_q != '0) bits_left_d = bits_left_q - 1'b1;
            if (bits_left_q == BLW'(1)) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (smp_en && auto_q && !open_q && bits_left_q == LEAD1) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bits_left_q <= '0;
      blk_left_q  <= '0;
      drain_q     <= 2'd0;
      stream_q    <= 1'b0;
      open_q      <= 1'b0;
      auto_q      <= 1'b0;
      stop_seen_q <= 1'b0;
      done_q      <= 1'b0;
      tmo_q       <= 1'b0;
      req_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      bits_left_q <= bits_left_d;
      blk_left_q  <= blk_left_d;
      drain_q     <= drain_d;
      stream_q    <= stream_d;
      open_q      <= open_d;
      auto_q      <= auto_d;
      stop_seen_q <= stop_seen_d;
      done_q      <= done_d;
      tmo_q       <= tmo_d;
      req_q       <= req_d;
    end
  end

  assign xfer_done     = done_q;
  assign data_timeout  = tmo_q;
  assign auto_stop_req = req_q;

  // R1
  start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMDW && cmd_end) |=> (state_q == ST_GAP) ##1
      (state_q == ST_RDWAIT || state_q == ST_RXSTRM));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  tmo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (state_q == ST_IDLE && $past(state_q) == ST_RDWAIT));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RXSTRM && fifo_full) |=> $stable(bits_left_q));

  // R7
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RXSTRM && drain_q == 2'd2) |=> (state_q == ST_IDLE && done_q));

  // R12
  auto_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (auto_q && !open_q));
endmodule

// File: rtl/sd_rx_engine.sv
module sd_rx_engine #(
  parameter int BCW       = 16,
  parameter int BSW       = 12,
  parameter int TW        = 24,
  parameter int AUTO_LEAD = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_load,
  input  logic           cmd_data_exp,
  input  logic           cmd_is_read,
  input  logic           cmd_end,
  input  logic           stop_end,
  input  logic           cfg_stream,
  input  logic [BCW-1:0] cfg_byte_cnt,
  input  logic [BSW-1:0] cfg_blk_size,
  input  logic           cfg_auto_stop,
  input  logic [TW-1:0]  cfg_timeout,
  input  logic           card_dat,
  input  logic           fifo_full,
  output logic           fifo_wr,
  output logic [7:0]     fifo_wdata,
  output logic           card_clk_hold,
  output logic           auto_stop_req,
  output logic           xfer_done,
  output logic           data_timeout
);
  localparam int DW = 8;

  logic wd_run, wd_expire, smp_en, des_clr;

  sdrx_ctrl #(
    .BCW       (BCW),
    .BSW       (BSW),
    .AUTO_LEAD (AUTO_LEAD)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_load      (cmd_load),
    .cmd_data_exp  (cmd_data_exp),
    .cmd_is_read   (cmd_is_read),
    .cmd_end       (cmd_end),
    .stop_end      (stop_end),
    .cfg_stream    (cfg_stream),
    .cfg_byte_cnt  (cfg_byte_cnt),
    .cfg_blk_size  (cfg_blk_size),
    .cfg_auto_stop (cfg_auto_stop),
    .din           (card_dat),
    .fifo_full     (fifo_full),
    .expire        (wd_expire),
    .wd_run        (wd_run),
    .smp_en        (smp_en),
    .des_clr       (des_clr),
    .rx_hold       (card_clk_hold),
    .xfer_done     (xfer_done),
    .data_timeout  (data_timeout),
    .auto_stop_req (auto_stop_req)
  );

  sdrx_deser #(.DW(DW)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (des_clr),
    .smp_en    (smp_en),
    .din       (card_dat),
    .byte_wr   (fifo_wr),
    .byte_data (fifo_wdata)
  );

  sdrx_wdog #(.TW(TW)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wd_run),
    .tick   (card_dat),
    .limit  (cfg_timeout),
    .expire (wd_expire)
  );

  // R8
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk_hold && !fifo_wr) |=> !fifo_wr);
endmodule

// File: tb/sim_sd_rx_engine.sv
module sim_sd_rx_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_load, cmd_data_exp, cmd_is_read, cmd_end, stop_end;
  logic        cfg_stream, cfg_auto_stop;
  logic [15:0] cfg_byte_cnt;
  logic [11:0] cfg_blk_size;
  logic [23:0] cfg_timeout;
  logic        card_dat, fifo_full;
  logic        fifo_wr, card_clk_hold, auto_stop_req, xfer_done, data_timeout;
  logic [7:0]  fifo_wdata;

  sd_rx_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_data_exp(cmd_data_exp),
    .cmd_is_read(cmd_is_read), .cmd_end(cmd_end), .stop_end(stop_end),
    .cfg_stream(cfg_stream), .cfg_byte_cnt(cfg_byte_cnt), .cfg_blk_size(cfg_blk_size),
    .cfg_auto_stop(cfg_auto_stop), .cfg_timeout(cfg_timeout), .card_dat(card_dat),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .card_clk_hold(card_clk_hold), .auto_stop_req(auto_stop_req),
    .xfer_done(xfer_done), .data_timeout(data_timeout)
  );

  always #2ns clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  logic [7:0] rx_buf [0:63];
  int rx_n, done_n, done_cyc, tmo_n, tmo_cyc, req_n, req_cyc, hold_n;
  logic tx [0:1023];
  int tx_n;
  int c0;

  always @(negedge clk) begin
    #1ns;
    if (fifo_wr && rx_n < 64) begin rx_buf[rx_n] = fifo_wdata; rx_n++; end
    if (xfer_done) begin done_n++; done_cyc = cyc; end
    if (data_timeout) begin tmo_n++; tmo_cyc = cyc; end
    if (auto_stop_req) begin req_n++; req_cyc = cyc; end
    if (card_clk_hold) hold_n++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_n = 0; done_n = 0; tmo_n = 0; req_n = 0; hold_n = 0;
    done_cyc = -1; tmo_cyc = -1; req_cyc = -1; tx_n = 0;
  endtask

  task automatic push_bit(input logic b);
    tx[tx_n] = b; tx_n++;
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) push_bit(b[i]);
  endtask

  task automatic push_ones(input int n);
    for (int i = 0; i < n; i++) push_bit(1'b1);
  endtask

  task automatic start_read(input logic strm, input int bc, input int bs,
                            input logic aut, input int tmo, input logic rd);
    @(negedge clk);
    cfg_stream = strm; cfg_byte_cnt = 16'(bc); cfg_blk_size = 12'(bs);
    cfg_auto_stop = aut; cfg_timeout = 24'(tmo);
    cmd_load = 1'b1; cmd_data_exp = 1'b1; cmd_is_read = rd;
    @(negedge clk);
    cmd_load = 1'b0;
    cmd_end = 1'b1;
    @(negedge clk);
    cmd_end = 1'b0;
    c0 = cyc;
  endtask

  task automatic card_play();
    for (int i = 0; i < tx_n; ) begin
      @(negedge clk);
      card_dat = tx[i];
      #1ns;
      if (!card_clk_hold) i++;
    end
    @(negedge clk);
    card_dat = 1'b1;
  endtask

  task automatic check_bytes(input string req, input logic [7:0] e0, input logic [7:0] e1,
                             input logic [7:0] e2, input logic [7:0] e3, input int n);
    logic [7:0] e [0:3];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    check(rx_n == n, req, rx_n, n);
    for (int i = 0; i < n && i < rx_n; i++)
      check(rx_buf[i] == e[i], req, int'(rx_buf[i]), int'(e[i]));
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R11
  task automatic t_reset();
    @(negedge clk); #1ns;
    check({fifo_wr, card_clk_hold, auto_stop_req, xfer_done, data_timeout} == 5'b0,
          "R11", int'({fifo_wr, card_clk_hold, auto_stop_req, xfer_done, data_timeout}), 0);
  endtask

  // R1: write-direction load ignored
  task automatic t_write_ignored();
    clear_mon();
    push_bit(1'b0); push_byte(8'h00); push_ones(2); push_bit(1'b0); push_byte(8'h55);
    start_read(1'b0, 2, 1, 1'b0, 5, 1'b0);
    card_play();
    settle(20);
    check(rx_n == 0, "R1 no write", rx_n, 0);
    check(done_n == 0 && tmo_n == 0, "R1 no done", done_n + tmo_n, 0);
  endtask

  // R3 R4 R2: fixed two-block read with idle bits
  task automatic t_block_fixed();
    clear_mon();
    push_ones(3); push_bit(1'b0); push_byte(8'h81); push_byte(8'h7E); push_ones(3);
    push_bit(1'b0); push_byte(8'hC3); push_byte(8'h19); push_ones(3);
    start_read(1'b0, 4, 2, 1'b0, 200, 1'b1);
    card_play();
    settle(10);
    check_bytes("R3 R4 block bytes", 8'h81, 8'h7E, 8'hC3, 8'h19, 4);
    check(done_n == 1, "R3 done", done_n, 1);
    check(tmo_n == 0, "R3 no timeout", tmo_n, 0);
  endtask

  // R5: open-ended blocks, stop during second block
  task automatic t_block_open();
    clear_mon();
    push_ones(2); push_bit(1'b0); push_byte(8'hA1); push_ones(3);
    push_bit(1'b0); push_byte(8'h4D); push_ones(3);
    push_bit(1'b0); push_byte(8'hEE); push_ones(3);
    start_read(1'b0, 0, 1, 1'b1, 200, 1'b1);
    fork
      card_play();
      begin
        repeat (18) @(negedge clk);
        stop_end = 1'b1;
        @(negedge clk);
        stop_end = 1'b0;
      end
    join
    settle(10);
    check_bytes("R5 open block bytes", 8'hA1, 8'h4D, 8'h00, 8'h00, 2);
    check(done_n == 1, "R5 done", done_n, 1);
    check(req_n == 0, "R12 open no auto", req_n, 0);
  endtask

  // R9: data timeout
  task automatic t_timeout();
    clear_mon();
    start_read(1'b0, 1, 1, 1'b0, 10, 1'b1);
    settle(20);
    check(tmo_n == 1 && tmo_cyc == c0 + 11, "R9 timeout cycle", tmo_cyc - c0, 11);
    check(done_n == 1 && done_cyc == c0 + 11, "R9 done with timeout", done_cyc - c0, 11);
    check(rx_n == 0, "R9 no data", rx_n, 0);
  endtask

  // R6 R1 R2: fixed stream, exact timing
  task automatic t_stream_fixed();
    clear_mon();
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'hF0);
    start_read(1'b1, 3, 1, 1'b0, 0, 1'b1);
    card_play();
    settle(6);
    check_bytes("R6 R1 R2 stream bytes", 8'hA5, 8'h3C, 8'hF0, 8'h00, 3);
    check(done_cyc == c0 + 25, "R6 done cycle", done_cyc - c0, 25);
    check(req_n == 0, "R12 auto off", req_n, 0);
  endtask

  // R8: FIFO full holds the card clock
  task automatic t_stream_hold();
    clear_mon();
    push_byte(8'h96); push_byte(8'h0F);
    start_read(1'b1, 2, 1, 1'b0, 0, 1'b1);
    fork
      card_play();
      begin
        repeat (5) @(negedge clk);
        fifo_full = 1'b1;
        repeat (4) @(negedge clk);
        fifo_full = 1'b0;
      end
    join
    settle(6);
    check(hold_n == 4, "R8 hold cycles", hold_n, 4);
    check_bytes("R8 bytes intact", 8'h96, 8'h0F, 8'h00, 8'h00, 2);
    check(done_cyc == c0 + 21, "R8 done delayed", done_cyc - c0, 21);
  endtask

  // R7: open stream ended by STOP
  task automatic t_stream_stop();
    int s0;
    clear_mon();
    push_byte(8'h12); push_byte(8'h34); push_byte(8'h56); push_byte(8'h78);
    start_read(1'b1, 0, 1, 1'b1, 0, 1'b1);
    card_play();
    @(negedge clk);
    stop_end = 1'b1;
    @(negedge clk);
    stop_end = 1'b0;
    s0 = cyc;
    settle(8);
    check(done_n == 1 && done_cyc == s0 + 2, "R7 done two after stop", done_cyc - s0, 2);
    check_bytes("R7 stream bytes", 8'h12, 8'h34, 8'h56, 8'h78, 4);
    check(req_n == 0, "R12 open stream no auto", req_n, 0);
  endtask

  // R10: auto-stop timing, long and short
  task automatic t_auto_long();
    clear_mon();
    for (int i = 0; i < 8; i++) push_byte(8'(8'h11 * i));
    start_read(1'b1, 8, 1, 1'b1, 0, 1'b1);
    card_play();
    settle(6);
    check(req_n == 1 && req_cyc == c0 + 17, "R10 long auto cycle", req_cyc - c0, 17);
    check(done_cyc == c0 + 65, "R6 long done", done_cyc - c0, 65);
  endtask

  task automatic t_auto_short();
    clear_mon();
    for (int i = 0; i < 4; i++) push_byte(8'hC0 + 8'(i));
    start_read(1'b1, 4, 1, 1'b1, 0, 1'b1);
    card_play();
    settle(6);
    check(req_n == 1 && req_cyc == c0 + 1, "R10 short auto cycle", req_cyc - c0, 1);
    check_bytes("R10 short bytes", 8'hC0, 8'hC1, 8'hC2, 8'hC3, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_load = 1'b0; cmd_data_exp = 1'b0; cmd_is_read = 1'b0; cmd_end = 1'b0;
    stop_end = 1'b0; cfg_stream = 1'b0; cfg_auto_stop = 1'b0;
    cfg_byte_cnt = '0; cfg_blk_size = 12'd1; cfg_timeout = 24'd100;
    card_dat = 1'b1; fifo_full = 1'b0;
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_ignored();
    t_block_fixed();
    t_block_open();
    t_timeout();
    t_stream_fixed();
    t_stream_hold();
    t_stream_stop();
    t_auto_long();
    t_auto_short();
    settle(4);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule